// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Unit

This block sits beside a processor bus and turns each bus address into one of eight active-low device selects. Every select has four settings: a base address, a mask, the access spaces it answers, and a wait-state count. A select that serves a slow device can be set to end the bus cycle on its own. In that case the block counts the programmed wait clocks and then drives the active-low transfer acknowledge itself. A select that serves a device with its own acknowledge waits for that device's acknowledge input instead.

Right after reset, select 0 answers every access, whatever the address or space. Boot code can therefore fetch its start-up vectors from the nonvolatile memory on select 0. Once software writes the select-0 mask register, select 0 decodes only its programmed window. The boot memory can then be moved high, for example to 0xFFE00000, which frees address 0 for RAM.

Software sets up the selects through a write-only register port. The bus side uses one active-low transfer-start pulse per cycle.

Top module: `cs_wait_unit`

## Requirements
- R1: While reset is held and right after it is released, all eight `cs_n` outputs and `ta_n` are high.
- R2: From reset until the select-0 mask register is first written, select 0 matches every access, regardless of address, space or valid bit. It uses the control register value it has after reset: BOOT_WAIT wait states (15 by default) and internal acknowledge.
- R3: After that first mask write, select i matches when `(bus_addr[31:16] & ~mask_i) == (base_i & ~mask_i)`, its valid bit is 1 and the access space is allowed. A select whose valid bit is 0 never matches.
- R4: Register port: `cfg_addr[4:2]` chooses the select, and `cfg_addr[1:0]` chooses the register (0 base, 1 mask, 2 control). In the control register, bit 0 is valid, bit 1 is external acknowledge, bits 5:2 are the wait count, bit 6 allows user, bit 7 allows supervisor, bit 8 allows program and bit 9 allows data. A write on `cfg_we` takes effect from the next clock.
- R5: If `bus_ts_n` is low at clock edge E0 and select i matches with internal acknowledge and W wait states, then `cs_n[i]` is low after edges E0 through E_W. `ta_n` is low only after edge E_W. Both are high again after edge E_(W+1).
- R6: When several selects match, only the lowest-numbered one asserts. When none matches, no select asserts and `ta_n` stays high.
- R7: A select matches only if `bus_super` (1 = supervisor, 0 = user) hits an allowed privilege and `bus_prog` (1 = program, 0 = data) hits an allowed kind.
- R8: For a select with external acknowledge set, `ta_n` stays high. The select stays low from the clock after transfer start through the clock in which `ext_ta_n` is sampled low, then goes high.
- R9: A transfer-start pulse that arrives while a cycle is in progress is ignored. The running cycle ends on its own schedule and no further cycle follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Select index and register number |
| cfg_wdata | input | 16 | Configuration write data |
| bus_addr | input | 32 | Processor address |
| bus_ts_n | input | 1 | Active-low transfer start |
| bus_super | input | 1 | 1 = supervisor access |
| bus_prog | input | 1 | 1 = program access |
| ext_ta_n | input | 1 | Active-low acknowledge from an external device |
| cs_n | output | 8 | Active-low chip selects |
| ta_n | output | 1 | Internally generated active-low transfer acknowledge |

## Verification
The FSM states are ST_IDLE, ST_WAIT, ST_ACK and ST_EXT. A start in ST_IDLE with a match goes to ST_ACK if W is 0, to ST_WAIT if W is above 0, or to ST_EXT for an external-acknowledge select. ST_WAIT counts down and moves to ST_ACK when its count reaches 1. ST_ACK always returns to ST_IDLE. ST_EXT returns to ST_IDLE when it samples the external acknowledge.

For each access, a select is due one clock after transfer start, the internal acknowledge is due W+1 clocks after it, and the release is due one clock after that. With no match, nothing changes in the clock after the start. The monitor sees the start at the rising edge, counts falling edges from there, and compares `cs_n` and `ta_n` at every falling edge up to and including the release.

// File: rtl/cs_pkg.sv
package cs_pkg;
    localparam int WAIT_W   = 4;
    localparam int REGION_W = 16;

    typedef struct packed {
        logic              allow_data;
        logic              allow_prog;
        logic              allow_super;
        logic              allow_user;
        logic [WAIT_W-1:0] waits;
        logic              ext_ack;
        logic              valid;
    } cs_ctrl_t;

    localparam int CTRL_W = $bits(cs_ctrl_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ACK,
        ST_EXT
    } bus_state_e;
endpackage

// File: rtl/cs_regfile.sv
module cs_regfile
    import cs_pkg::*;
#(
    parameter int N_CS      = 8,
    parameter int BOOT_WAIT = 15,
    localparam int IDX_W    = $clog2(N_CS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W+1:0]    cfg_addr,
    input  logic [REGION_W-1:0] cfg_wdata,
    output logic [REGION_W-1:0] base_o [N_CS],
    output logic [REGION_W-1:0] mask_o [N_CS],
    output cs_ctrl_t            ctrl_o [N_CS],
    output logic                boot_o
);
    localparam cs_ctrl_t BOOT_CTRL = '{allow_data: 1'b0, allow_prog: 1'b0,
                                       allow_super: 1'b0, allow_user: 1'b0,
                                       waits: WAIT_W'(BOOT_WAIT),
                                       ext_ack: 1'b0, valid: 1'b0};

    logic [IDX_W-1:0] wr_idx;
    logic [1:0]       wr_reg;
    logic             unused_wdata_hi;

    assign wr_idx          = cfg_addr[IDX_W+1:2];
    assign wr_reg          = cfg_addr[1:0];
    assign unused_wdata_hi = ^cfg_wdata[REGION_W-1:CTRL_W];

    for (genvar i = 0; i < N_CS; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_o[i] <= '0;
                mask_o[i] <= '0;
                ctrl_o[i] <= (i == 0) ? BOOT_CTRL : '0;
            end else if (cfg_we && wr_idx == IDX_W'(i)) begin
                unique case (wr_reg)
                    2'd0:    base_o[i] <= cfg_wdata;
                    2'd1:    mask_o[i] <= cfg_wdata;
                    2'd2:    ctrl_o[i] <= cs_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            boot_o <= 1'b1;
        else if (cfg_we && wr_idx == '0 && wr_reg == 2'd1)
            boot_o <= 1'b0;
    end
endmodule

// File: rtl/cs_decode.sv
module cs_decode
    import cs_pkg::*;
#(
    parameter int N_CS   = 8,
    localparam int IDX_W = $clog2(N_CS)
) (
    input  logic [REGION_W-1:0] addr_hi,
    input  logic                super_i,
    input  logic                prog_i,
    input  logic                boot_i,
    input  logic [REGION_W-1:0] base_i [N_CS],
    input  logic [REGION_W-1:0] mask_i [N_CS],
    input  cs_ctrl_t            ctrl_i [N_CS],
    output logic                hit_o,
    output logic [IDX_W-1:0]    sel_o
);
    logic [N_CS-1:0] match;

    for (genvar i = 0; i < N_CS; i++) begin : g_cmp
        logic in_range, space_ok;
        assign in_range = ((addr_hi ^ base_i[i]) & ~mask_i[i]) == '0;
        assign space_ok = (super_i ? ctrl_i[i].allow_super : ctrl_i[i].allow_user) &&
                          (prog_i  ? ctrl_i[i].allow_prog  : ctrl_i[i].allow_data);
        if (i == 0) begin : g_boot
            assign match[i] = boot_i || (ctrl_i[i].valid && in_range && space_ok);
        end else begin : g_norm
            assign match[i] = ctrl_i[i].valid && in_range && space_ok;
        end
    end

    always_comb begin
        hit_o = |match;
        sel_o = '0;
        for (int i = N_CS - 1; i >= 0; i--) begin
            if (match[i]) sel_o = IDX_W'(i);
        end
    end
endmodule

// File: rtl/cs_fsm.sv
module cs_fsm
    import cs_pkg::*;
#(
    parameter int N_CS   = 8,
    localparam int IDX_W = $clog2(N_CS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ts_n,
    input  logic              ext_ta_n,
    input  logic              hit,
    input  logic [IDX_W-1:0]  sel,
    input  logic [WAIT_W-1:0] sel_waits,
    input  logic              sel_ext,
    output logic [N_CS-1:0]   cs_n,
    output logic              ta_n
);
    bus_state_e        state_q, state_d;
    logic [WAIT_W-1:0] cnt_q, cnt_d;
    logic [IDX_W-1:0]  sel_q, sel_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        sel_d   = sel_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!ts_n && hit) begin
                    sel_d = sel;
                    cnt_d = sel_waits;
                    if (sel_ext)             state_d = ST_EXT;
                    else if (sel_waits == 0) state_d = ST_ACK;
                    else                     state_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (cnt_q == WAIT_W'(1)) state_d = ST_ACK;
                else                     cnt_d   = cnt_q - 1'b1;
            end
            ST_ACK:  state_d = ST_IDLE;
            ST_EXT:  if (!ext_ta_n) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sel_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            sel_q   <= sel_d;
        end
    end

    always_comb begin
        cs_n = '1;
        if (state_q != ST_IDLE) cs_n[sel_q] = 1'b0;
        ta_n = (state_q != ST_ACK);
    end
endmodule

// File: rtl/cs_wait_unit.sv
module cs_wait_unit
    import cs_pkg::*;
#(
    parameter int N_CS      = 8,
    parameter int BOOT_WAIT = 15,
    localparam int IDX_W    = $clog2(N_CS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W+1:0]    cfg_addr,
    input  logic [REGION_W-1:0] cfg_wdata,
    input  logic [31:0]         bus_addr,
    input  logic                bus_ts_n,
    input  logic                bus_super,
    input  logic                bus_prog,
    input  logic                ext_ta_n,
    output logic [N_CS-1:0]     cs_n,
    output logic                ta_n
);
    logic [REGION_W-1:0] base [N_CS];
    logic [REGION_W-1:0] mask [N_CS];
    cs_ctrl_t            ctrl [N_CS];
    logic                boot_q;
    logic                hit;
    logic [IDX_W-1:0]    sel;
    logic                unused_addr_lo;

    assign unused_addr_lo = ^bus_addr[31-REGION_W:0];

    cs_regfile #(.N_CS(N_CS), .BOOT_WAIT(BOOT_WAIT)) regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .base_o(base), .mask_o(mask), .ctrl_o(ctrl),
        .boot_o(boot_q)
    );

    cs_decode #(.N_CS(N_CS)) dec_i (
        .addr_hi(bus_addr[31:32-REGION_W]), .super_i(bus_super),
        .prog_i(bus_prog), .boot_i(boot_q), .base_i(base), .mask_i(mask),
        .ctrl_i(ctrl), .hit_o(hit), .sel_o(sel)
    );

    cs_fsm #(.N_CS(N_CS)) fsm_i (
        .clk(clk), .rst_n(rst_n), .ts_n(bus_ts_n), .ext_ta_n(ext_ta_n),
        .hit(hit), .sel(sel), .sel_waits(ctrl[sel].waits),
        .sel_ext(ctrl[sel].ext_ack), .cs_n(cs_n), .ta_n(ta_n)
    );
endmodule

// File: rtl/cs_wait_unit_chk.sv
module cs_wait_unit_chk #(
    parameter int N_CS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            bus_ts_n,
    input logic            ext_ta_n,
    input logic            boot_q,
    input logic [N_CS-1:0] cs_n,
    input logic            ta_n
);
    AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1); // R6

    AST_TA_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !ta_n |-> !(&cs_n)); // R5

    AST_RELEASE_AFTER_TA: assert property (@(posedge clk) disable iff (!rst_n)
        !ta_n |=> &cs_n); // R5

    AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && ta_n && ext_ta_n) |=> $stable(cs_n)); // R9

    AST_BOOT_CS0: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_q && !bus_ts_n && (&cs_n)) |=> !cs_n[0]); // R2

    AST_IDLE_NO_TA: assert property (@(posedge clk) disable iff (!rst_n)
        (&cs_n) |-> ta_n); // R6
endmodule

bind cs_wait_unit cs_wait_unit_chk #(.N_CS(N_CS)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_ts_n(bus_ts_n), .ext_ta_n(ext_ta_n),
    .boot_q(boot_q), .cs_n(cs_n), .ta_n(ta_n)
);

// File: tb/cs_wait_unit_tb_top.sv
module cs_wait_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [31:0] bus_addr = '0;
    logic        bus_ts_n = 1'b1;
    logic        bus_super = 1'b1;
    logic        bus_prog = 1'b1;
    logic        ext_ta_n = 1'b1;
    logic [7:0]  cs_n;
    logic        ta_n;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    sel;
        int    lat;
        bit    ext;
        string req;
    } exp_t;
    exp_t exp_q[$];

    always #4 clk = ~clk;

    cs_wait_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bus_addr(bus_addr), .bus_ts_n(bus_ts_n),
        .bus_super(bus_super), .bus_prog(bus_prog), .ext_ta_n(ext_ta_n),
        .cs_n(cs_n), .ta_n(ta_n)
    );

    task automatic chk(string req, logic [8:0] act, logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: {cs_n,ta_n} actual %b expected %b", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk_ctrl(bit valid, bit ext, int waits,
                                            bit usr, bit sup, bit prg, bit dat);
        return {6'b0, dat, prg, sup, usr, 4'(waits), ext, valid};
    endfunction

    task automatic cfg_write(int idx, int rsel, logic [15:0] data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = {3'(idx), 2'(rsel)};
        cfg_wdata = data;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic access(logic [31:0] addr, bit sup, bit prg, int sel, int lat,
                          bit ext, bit stray, string req);
        exp_t e;
        e.sel = sel; e.lat = lat; e.ext = ext; e.req = req;
        @(negedge clk);
        bus_addr = addr; bus_super = sup; bus_prog = prg; bus_ts_n = 1'b0;
        exp_q.push_back(e);
        @(negedge clk);
        bus_ts_n = 1'b1;
        if (ext) begin
            repeat (lat - 1) @(negedge clk);
            ext_ta_n = 1'b0;
            @(negedge clk);
            ext_ta_n = 1'b1;
        end else if (stray) begin
            @(negedge clk);
            bus_ts_n = 1'b0;            // R9 stray start mid-cycle
            @(negedge clk);
            bus_ts_n = 1'b1;
            repeat (lat) @(negedge clk);
        end else begin
            repeat (lat + 1) @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    // Monitor: pops one expected item per observed transfer start.
    initial begin
        forever begin
            @(posedge clk);
            if (rst_n && !bus_ts_n) begin
                if (exp_q.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R9: unexpected transfer start, actual 1 expected 0");
                end else begin
                    exp_t e;
                    logic [7:0] cs_exp;
                    e = exp_q.pop_front();
                    cs_exp = (e.sel >= 0) ? ~(8'(1) << e.sel) : 8'hFF;
                    if (e.sel >= 0) begin
                        for (int k = 1; k <= e.lat; k++) begin
                            @(negedge clk);
                            chk(e.req, {cs_n, ta_n},
                                {cs_exp, !(!e.ext && k == e.lat)});
                        end
                    end
                    @(negedge clk);
                    chk(e.req, {cs_n, ta_n}, 9'h1FF);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", {cs_n, ta_n}, 9'h1FF);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {cs_n, ta_n}, 9'h1FF);

        // R2: boot window, any address and space selects 0 with 15 waits
        access(32'h0000_0000, 1, 1, 0, 16, 0, 0, "R2");
        access(32'h1234_5678, 0, 0, 0, 16, 0, 0, "R2");

        // R4: program select 1 as RAM at 0, 2 waits
        cfg_write(1, 0, 16'h0000);
        cfg_write(1, 1, 16'h003F);
        cfg_write(1, 2, mk_ctrl(1, 0, 2, 1, 1, 1, 1));
        access(32'h0000_0004, 1, 1, 0, 16, 0, 0, "R2");

        // R3: move select 0 high, then end the boot window
        cfg_write(0, 2, mk_ctrl(1, 0, 1, 1, 1, 1, 1));
        cfg_write(0, 0, 16'hFFE0);
        cfg_write(0, 1, 16'h000F);
        access(32'h0000_0004, 1, 1, 1, 3, 0, 0, "R3");
        access(32'hFFE0_0004, 1, 1, 0, 2, 0, 0, "R3");
        access(32'h2000_0000, 1, 1, -1, 0, 0, 0, "R6");

        // R6: overlapping select 2, zero waits
        cfg_write(2, 0, 16'hFFE0);
        cfg_write(2, 1, 16'h00FF);
        cfg_write(2, 2, mk_ctrl(1, 0, 0, 1, 1, 1, 1));
        access(32'hFFE8_0000, 1, 1, 0, 2, 0, 0, "R6");
        access(32'hFFF0_0000, 1, 1, 2, 1, 0, 0, "R5");

        // R7: select 3 supervisor data only
        cfg_write(3, 0, 16'h4000);
        cfg_write(3, 2, mk_ctrl(1, 0, 3, 0, 1, 0, 1));
        access(32'h4000_0000, 0, 0, -1, 0, 0, 0, "R7");
        access(32'h4000_0000, 1, 1, -1, 0, 0, 0, "R7");
        access(32'h4000_0000, 1, 0, 3, 4, 0, 0, "R7");

        // R8: select 4 with external acknowledge
        cfg_write(4, 0, 16'h3000);
        cfg_write(4, 1, 16'h000F);
        cfg_write(4, 2, mk_ctrl(1, 1, 0, 1, 1, 1, 1));
        access(32'h3001_0000, 1, 1, 4, 5, 1, 0, "R8");
        access(32'h3002_0000, 0, 0, 4, 1, 1, 0, "R8");

        // R3: select 5 configured but not valid
        cfg_write(5, 0, 16'h5000);
        cfg_write(5, 2, mk_ctrl(0, 0, 0, 1, 1, 1, 1));
        access(32'h5000_0000, 1, 1, -1, 0, 0, 0, "R3");

        // R5/R9: select 6 with maximum waits and a stray start
        cfg_write(6, 0, 16'h6000);
        cfg_write(6, 1, 16'h0FFF);
        cfg_write(6, 2, mk_ctrl(1, 0, 15, 1, 1, 1, 1));
        access(32'h6123_0000, 1, 1, 6, 16, 0, 0, "R5");
        access(32'h6123_0000, 1, 1, 6, 16, 0, 1, "R9");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL R5: %0d accesses not observed, expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule